// File: doc/BRIEF.md
# Two-Level Decoded Bus Slave with Interrupt

This block is a slave agent on a shared parallel bus. The bus carries an address, a small control group (space select, direction and a cycle strobe) and data in both directions. The slave watches every bus cycle and reacts to exactly one address in one space. A write to that address stores the bus data in a device register. A read from it places the register on the return data lines through an output enable, as a tri-state driver would. Every accepted cycle is acknowledged to the master. A device event can raise an interrupt request, and that request stays up until the master next touches the device.

Decoding runs in two stages. The output of the first stage gates the second. Parameters set the base address, the space and which directions are accepted. A further parameter sets the order of the stages: address first, or function first. Both orders produce the same final select.

Top module: `bus_slave_agent`

## Requirements
- R1: While `rst_n` is low at a clock edge, `bus_ack`, `bus_rdata_oe` and `irq_req` go low and the device register goes to zero.
- R2: A cycle is accepted only when `bus_addr` equals `BASE_ADDR` and `bus_io` equals the configured space (1 = I/O, 0 = memory; default I/O at 0x0F). A cycle to any other address, or to the other space, never raises `bus_ack`.
- R3: `bus_ack` rises on the first clock edge at which `bus_strobe` is high with an accepted cycle. It stays high while `bus_strobe` stays high and falls on the first edge that sees `bus_strobe` low.
- R4: An accepted write (`bus_wr` = 1) loads `bus_wdata` into the device register on the edge where `bus_ack` rises. A write that is not accepted leaves the register unchanged.
- R5: On an accepted read (`bus_wr` = 0), `bus_rdata_oe` rises and falls on the same edges as `bus_ack`, and `bus_rdata` shows the register while the enable is high. `bus_rdata` is all zeros while the enable is low.
- R6: `bus_rdata_oe` never goes high during a write cycle.
- R7: The decode order parameter (`ADDR_FIRST` = 1 or 0) does not change which cycles are accepted, or when they are acknowledged.
- R8: A high `dev_event` at a clock edge sets `irq_req`. The edge that raises `bus_ack` clears it. If `dev_event` is high on that same edge, the set wins. Cycles that are not accepted leave `irq_req` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | ADDR_W | Address lines |
| bus_io | input | 1 | Space select: 1 = I/O, 0 = memory |
| bus_wr | input | 1 | Direction: 1 = write, 0 = read |
| bus_strobe | input | 1 | High while a bus cycle is in progress |
| bus_wdata | input | DATA_W | Write data from the master |
| bus_rdata | output | DATA_W | Read data, zero unless enabled |
| bus_rdata_oe | output | 1 | Read data output enable (tri-state control) |
| bus_ack | output | 1 | Cycle completion acknowledge |
| dev_event | input | 1 | Device event that requests an interrupt |
| irq_req | output | 1 | Interrupt request to the master |

## Verification
The bench aims writes at a neighbouring address and at the same address in memory space, then reads the register back. An incomplete decoder would either acknowledge these cycles or overwrite the stored value. It holds the strobe for several cycles, so an acknowledge that pulses once, or one that outlives the strobe, is caught on the exact edge. It runs a second instance with the opposite stage order on the same bus, so a gating error in one order shows up as a mismatch. It also raises the device event on the very edge of an accepted access: a clear-first priority would lose the interrupt.

// File: rtl/bus_slave_pkg.sv
// Shared types for the bus slave agent.
// Assumes nothing beyond IEEE 1800-2017 packages.
package bus_slave_pkg;

    // Handshake phase of one bus cycle as seen by the slave.
    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_BUSY_WR = 2'd1,
        PH_BUSY_RD = 2'd2
    } phase_e;

    localparam logic SPACE_MEM = 1'b0;
    localparam logic SPACE_IO  = 1'b1;

endpackage

// File: rtl/slave_decode.sv
// Two-level full decoder. Stage one matches either the address or the
// function (space + direction), and its output gates stage two, which
// matches the other half. The result is one select per direction.
// Assumes the bus inputs are stable while bus_strobe is high.
module slave_decode #(
    parameter int              ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h0F,
    parameter logic            SPACE      = 1'b1,
    parameter bit              ACCEPT_WR  = 1'b1,
    parameter bit              ACCEPT_RD  = 1'b1,
    parameter bit              ADDR_FIRST = 1'b1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              io,
    input  logic              wr,
    input  logic              strobe,
    output logic              sel_wr,
    output logic              sel_rd
);

    logic addr_hit;
    logic func_hit;
    logic stage1;
    logic stage2;

    // Raw comparisons used by the two stages.
    always_comb begin
        addr_hit = (addr == BASE_ADDR);
        func_hit = strobe && (io == SPACE) && (wr ? ACCEPT_WR : ACCEPT_RD);
    end

    // Stage order chosen by parameter; the first stage enables the second.
    generate
        if (ADDR_FIRST) begin : g_addr_first
            always_comb begin
                stage1 = addr_hit;
                stage2 = stage1 ? func_hit : 1'b0;
            end
        end else begin : g_func_first
            always_comb begin
                stage1 = func_hit;
                stage2 = stage1 ? addr_hit : 1'b0;
            end
        end
    endgenerate

    // Split the final select by direction.
    always_comb begin
        sel_wr = stage2 && wr;
        sel_rd = stage2 && !wr;
    end

endmodule

// File: rtl/slave_handshake.sv
// Acknowledge sequencer. Enters a busy phase on the first edge that sees
// a select, holds it while the strobe stays high, and returns to idle on
// the first edge without the strobe. The start pulse marks the entry edge.
// Assumes at most one of sel_wr / sel_rd is high.
module slave_handshake
    import bus_slave_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic sel_wr,
    input  logic sel_rd,
    output logic start,
    output logic ack,
    output logic rd_oe
);

    phase_e phase_q;
    phase_e phase_d;

    // Next phase and start pulse.
    always_comb begin
        phase_d = phase_q;
        start   = 1'b0;
        case (phase_q)
            PH_IDLE: begin
                if (sel_rd) begin
                    phase_d = PH_BUSY_RD;
                    start   = 1'b1;
                end else if (sel_wr) begin
                    phase_d = PH_BUSY_WR;
                    start   = 1'b1;
                end
            end
            default: begin
                if (!strobe) phase_d = PH_IDLE;
            end
        endcase
    end

    // Phase register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    // Outputs decoded straight from the phase register.
    always_comb begin
        ack   = (phase_q != PH_IDLE);
        rd_oe = (phase_q == PH_BUSY_RD);
    end

endmodule

// File: rtl/slave_device_reg.sv
// Device register and interrupt flag. The register loads on a write start;
// the flag sets on a device event and clears on any access start, with the
// set taking priority when both land on the same edge.
module slave_device_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              sel_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              dev_event,
    output logic [DATA_W-1:0] value,
    output logic              irq
);

    // Data storage, loaded once per accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n)                value <= '0;
        else if (start && sel_wr)  value <= wdata;
    end

    // Interrupt request flag: event sets, access start clears.
    always_ff @(posedge clk) begin
        if (!rst_n)         irq <= 1'b0;
        else if (dev_event) irq <= 1'b1;
        else if (start)     irq <= 1'b0;
    end

endmodule

// File: rtl/bus_slave_agent.sv
// Top of the bus slave agent: two-level decoder, acknowledge sequencer,
// device register with interrupt flag, and a gated read data driver that
// stands in for a tri-state buffer. Assumes a single synchronous clock.
module bus_slave_agent #(
    parameter int                ADDR_W     = 8,
    parameter int                DATA_W     = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR  = 8'h0F,
    parameter logic              SPACE      = 1'b1,
    parameter bit                ACCEPT_WR  = 1'b1,
    parameter bit                ACCEPT_RD  = 1'b1,
    parameter bit                ADDR_FIRST = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_io,
    input  logic              bus_wr,
    input  logic              bus_strobe,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rdata_oe,
    output logic              bus_ack,
    input  logic              dev_event,
    output logic              irq_req
);

    logic              sel_wr;
    logic              sel_rd;
    logic              start;
    logic [DATA_W-1:0] dev_value;

    slave_decode #(
        .ADDR_W     (ADDR_W),
        .BASE_ADDR  (BASE_ADDR),
        .SPACE      (SPACE),
        .ACCEPT_WR  (ACCEPT_WR),
        .ACCEPT_RD  (ACCEPT_RD),
        .ADDR_FIRST (ADDR_FIRST)
    ) u_decode (
        .addr   (bus_addr),
        .io     (bus_io),
        .wr     (bus_wr),
        .strobe (bus_strobe),
        .sel_wr (sel_wr),
        .sel_rd (sel_rd)
    );

    slave_handshake u_hs (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (bus_strobe),
        .sel_wr (sel_wr),
        .sel_rd (sel_rd),
        .start  (start),
        .ack    (bus_ack),
        .rd_oe  (bus_rdata_oe)
    );

    slave_device_reg #(
        .DATA_W (DATA_W)
    ) u_dev (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .sel_wr    (sel_wr),
        .wdata     (bus_wdata),
        .dev_event (dev_event),
        .value     (dev_value),
        .irq       (irq_req)
    );

    // Read data driver: passes the register only while enabled.
    always_comb begin
        bus_rdata = bus_rdata_oe ? dev_value : '0;
    end

endmodule

// File: rtl/bus_slave_agent_chk.sv
// Protocol checker for bus_slave_agent, attached by bind. Observes ports only.
module bus_slave_agent_chk #(
    parameter int                ADDR_W    = 8,
    parameter int                DATA_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h0F,
    parameter logic              SPACE     = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_io,
    input logic              bus_wr,
    input logic              bus_strobe,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              bus_rdata_oe,
    input logic              bus_ack,
    input logic              dev_event,
    input logic              irq_req
);

    // R2: an acknowledge only ever follows a cycle at the configured location.
    a_r2_ack_only_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_ack) |-> ($past(bus_addr) == BASE_ADDR && $past(bus_io) == SPACE
                            && $past(bus_strobe)));

    // R3: acknowledge holds while the strobe stays high.
    a_r3_ack_held: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ack && bus_strobe) |=> bus_ack);

    // R3: acknowledge drops on the edge after the strobe is gone.
    a_r3_ack_released: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_strobe |=> !bus_ack);

    // R5: the output enable is never up without the acknowledge.
    a_r5_oe_within_ack: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata_oe |-> bus_ack);

    // R5: the data lines stay quiet while not enabled.
    a_r5_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rdata_oe |-> (bus_rdata == '0));

    // R6: the enable only comes up for a read.
    a_r6_oe_read_only: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_rdata_oe) |-> !$past(bus_wr));

    // R8: a device event always leaves the request raised.
    a_r8_event_sets_irq: assert property (@(posedge clk) disable iff (!rst_n)
        dev_event |=> irq_req);

endmodule

bind bus_slave_agent bus_slave_agent_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .BASE_ADDR (BASE_ADDR),
    .SPACE     (SPACE)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_io       (bus_io),
    .bus_wr       (bus_wr),
    .bus_strobe   (bus_strobe),
    .bus_rdata    (bus_rdata),
    .bus_rdata_oe (bus_rdata_oe),
    .bus_ack      (bus_ack),
    .dev_event    (dev_event),
    .irq_req      (irq_req)
);

// File: tb/sim_bus_slave_agent.sv
// Directed bench: one task per scenario, inputs driven 1 ns after the
// rising edge and outputs sampled at the same point, once registers settle.
module sim_bus_slave_agent;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = '0;
    logic       bus_io = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_strobe = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic       dev_event = 1'b0;
    logic [7:0] bus_rdata, u1_rdata;
    logic       bus_rdata_oe, u1_oe;
    logic       bus_ack, u1_ack;
    logic       irq_req, u1_irq;

    int n_checks = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    bus_slave_agent u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_io(bus_io),
        .bus_wr(bus_wr), .bus_strobe(bus_strobe), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rdata_oe(bus_rdata_oe), .bus_ack(bus_ack),
        .dev_event(dev_event), .irq_req(irq_req)
    );

    bus_slave_agent #(.ADDR_FIRST(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_io(bus_io),
        .bus_wr(bus_wr), .bus_strobe(bus_strobe), .bus_wdata(bus_wdata),
        .bus_rdata(u1_rdata), .bus_rdata_oe(u1_oe), .bus_ack(u1_ack),
        .dev_event(dev_event), .irq_req(u1_irq)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // R7: the reversed-order instance must agree with u0 at every sample.
    task automatic check_order();
        check(u1_ack == bus_ack, "R7 ack order", u1_ack, bus_ack);
        check(u1_rdata == bus_rdata, "R7 rdata order", u1_rdata, bus_rdata);
    endtask

    // One bus cycle held for `hold` edges; checks R2/R3/R4/R5/R6 timing.
    task automatic bus_cycle(input logic [7:0] a, input logic io, input logic wr,
                             input logic [7:0] wd, input bit hit, input int hold,
                             input logic [7:0] exp_rd);
        bus_addr = a; bus_io = io; bus_wr = wr; bus_wdata = wd; bus_strobe = 1'b1;
        for (int i = 0; i < hold; i++) begin
            tick();
            check(bus_ack == hit, "R2/R3 ack during strobe", bus_ack, hit);
            check(bus_rdata_oe == (hit && !wr), "R5/R6 oe during strobe",
                  bus_rdata_oe, hit && !wr);
            if (hit && !wr)
                check(bus_rdata == exp_rd, "R5 read data", bus_rdata, exp_rd);
            else
                check(bus_rdata == 8'h00, "R5 data quiet", bus_rdata, 8'h00);
            check_order();
        end
        bus_strobe = 1'b0;
        tick();
        check(bus_ack == 1'b0, "R3 ack released", bus_ack, 1'b0);
        check(bus_rdata_oe == 1'b0, "R5 oe released", bus_rdata_oe, 1'b0);
        check_order();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        tick(); tick();
        check(bus_ack == 1'b0, "R1 ack reset", bus_ack, 1'b0);
        check(bus_rdata_oe == 1'b0, "R1 oe reset", bus_rdata_oe, 1'b0);
        check(irq_req == 1'b0, "R1 irq reset", irq_req, 1'b0);
        rst_n = 1'b1;
        tick();
        bus_cycle(8'h0F, 1'b1, 1'b0, 8'h00, 1'b1, 1, 8'h00); // R1 register zero
    endtask

    task automatic t_write_read();
        bus_cycle(8'h0F, 1'b1, 1'b1, 8'hA5, 1'b1, 1, 8'h00); // R4 write
        bus_cycle(8'h0F, 1'b1, 1'b0, 8'h00, 1'b1, 1, 8'hA5); // R4 readback
        bus_cycle(8'h0F, 1'b1, 1'b1, 8'h3C, 1'b1, 4, 8'h00); // R3 long write, R6
        bus_cycle(8'h0F, 1'b1, 1'b0, 8'h00, 1'b1, 3, 8'h3C); // R5 long read
    endtask

    task automatic t_ignore();
        bus_cycle(8'h0E, 1'b1, 1'b1, 8'hFF, 1'b0, 2, 8'h00); // R2 wrong address
        bus_cycle(8'h8F, 1'b1, 1'b1, 8'hEE, 1'b0, 1, 8'h00); // R2 high bit differs
        bus_cycle(8'h0F, 1'b0, 1'b1, 8'hDD, 1'b0, 2, 8'h00); // R2 memory space
        bus_cycle(8'h0F, 1'b0, 1'b0, 8'h00, 1'b0, 1, 8'h00); // R2 memory read
        bus_cycle(8'h0F, 1'b1, 1'b0, 8'h00, 1'b1, 1, 8'h3C); // R4 unchanged
    endtask

    task automatic t_irq();
        dev_event = 1'b1;
        tick();
        dev_event = 1'b0;
        check(irq_req == 1'b1, "R8 irq set", irq_req, 1'b1);
        bus_cycle(8'h0E, 1'b1, 1'b0, 8'h00, 1'b0, 1, 8'h00);
        check(irq_req == 1'b1, "R8 irq kept on miss", irq_req, 1'b1);
        bus_cycle(8'h0F, 1'b1, 1'b0, 8'h00, 1'b1, 1, 8'h3C);
        check(irq_req == 1'b0, "R8 irq cleared by access", irq_req, 1'b0);
        // Event on the very edge that starts an access: set wins.
        bus_addr = 8'h0F; bus_io = 1'b1; bus_wr = 1'b1; bus_wdata = 8'h77;
        bus_strobe = 1'b1; dev_event = 1'b1;
        tick();
        dev_event = 1'b0;
        check(bus_ack == 1'b1, "R3 ack on coincident access", bus_ack, 1'b1);
        check(irq_req == 1'b1, "R8 set wins over clear", irq_req, 1'b1);
        check(u1_irq == irq_req, "R7 irq order", u1_irq, irq_req);
        bus_strobe = 1'b0;
        tick();
        check(bus_ack == 1'b0, "R3 ack released", bus_ack, 1'b0);
        bus_cycle(8'h0F, 1'b1, 1'b0, 8'h00, 1'b1, 1, 8'h77); // R4 coincident write
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        t_reset();
        t_write_read();
        t_ignore();
        t_irq();
        finish_run();
    end

endmodule